// File: doc/BRIEF.md
# Response Ring Writer with Interrupt

This block sits between a codec link receiver and system memory. Every response that arrives from the link has two 32-bit words: the reply and an extended word. The block stores each one as an 8-byte entry in a 256-entry circular ring in memory. A hardware write pointer is advanced before each store, so the newest entry is always at the slot the pointer names. Software drains the ring from its own side and gives its read position back through an input, so the writer can see when the ring is full.

A small register set holds the ring base, the write pointer, an interrupt threshold, a control byte and a status byte. The ring only takes data while its DMA enable bit is set. A response-interrupt status bit is set each time the programmed number of responses has been stored. When a store would run into the software read position, the response is dropped and a separate overrun status bit is set. Both status bits are write-1-to-clear, and one interrupt line combines them. Unsolicited events, which are marked by bit 4 of the extended word, pass through to memory unchanged. They count toward the threshold in the same way as solicited replies.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset the write pointer reads 0, the status reads 0, `mem_we_o` and `irq_o` are low, and the size register (select 5) reads 0x02.
- R2: With control bit 1 set, each response first advances the write pointer by one modulo 256. In the next cycle it makes exactly one memory write to base + 8 × (new pointer), with the reply in data bits 31:0 and the extended word in bits 63:32.
- R3: With control bit 1 clear, responses are ignored: no memory write, the pointer is unchanged and no status bit is set.
- R4: A register write to select 1 with bit 15 set returns the pointer and the threshold count to 0, so the next store goes to entry 1. This clear wins over a response in the same cycle, and that response is dropped. A write to select 1 with bit 15 clear changes nothing.
- R5: The threshold register (select 2, 8 bits) holds N, where 0 means 256. Status bit 0 is set on the Nth response stored since the last time the threshold was reached or the pointer was cleared. The count then starts again.
- R6: Bit 4 of the extended word (unsolicited marker) is stored without change. Such responses count toward the threshold in the same way as solicited ones.
- R7: If the advanced pointer would equal the software read position `sw_rp_i`, the response is not written, the pointer is unchanged and status bit 2 (overrun) is set.
- R8: Writing 1 to status bit 0 or bit 2 (select 4) clears that bit, and writing 0 leaves it as it is. If a set event happens in the same cycle as the clear, the bit stays set.
- R9: `irq_o` equals (status bit 0 AND control bit 0) OR status bit 2.
- R10: Base (select 0, all 32 bits), threshold (low 8 bits), control (bits 1:0) and the write pointer (select 1, low 8 bits) read back through `reg_rdata_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsp_valid_i | input | 1 | A response is present this cycle |
| rsp_data_i | input | 32 | Response word |
| rsp_ext_i | input | 32 | Extended word; bit 4 marks an unsolicited event |
| sw_rp_i | input | 8 | Software read position in the ring |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 base, 1 pointer, 2 threshold, 3 control, 4 status, 5 size |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the current select |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 64 | Entry: extended word in bits 63:32, response in bits 31:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following: the store timing and address against the previous pointer, the silence when DMA is off, the drop and flag when the ring is full, the pointer clear winning over a response, the write-1-to-clear of overrun, and the fact that overrun always drives the interrupt. Only the bench scenarios can show threshold counting over many responses and its restart after a clear, as well as pointer wrap past 255. The same is true of the set-wins-over-clear race on the response status bit and the unchanged storage of unsolicited markers. The bench compares every write, status and interrupt against a reference model, using both random and directed traffic.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_WPTR = 3'd1,
    SEL_ICNT = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_STAT = 3'd4,
    SEL_SIZE = 3'd5
  } rsp_sel_e;

  localparam int CTRL_IRQ_BIT  = 0;
  localparam int CTRL_DMA_BIT  = 1;
  localparam int STAT_RESP_BIT = 0;
  localparam int STAT_OVR_BIT  = 2;
  localparam int WPTR_CLR_BIT  = 15;
  localparam int EXT_UNSOL_BIT = 4;

  typedef struct packed {
    logic [31:0] ext;
    logic [31:0] data;
  } rsp_entry_t;

  // ring size encoding: 2, 16, 256 entries
  function automatic logic [7:0] size_code(input int ptr_w);
    case (ptr_w)
      1:       return 8'h00;
      4:       return 8'h01;
      8:       return 8'h02;
      default: return 8'hff;
    endcase
  endfunction

endpackage

// File: rtl/rsp_ring_regs.sv
module rsp_ring_regs
  import rsp_ring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic [PTR_W-1:0] wp_i,
  input  logic             resp_ev_i,
  input  logic             ovr_ev_i,
  output logic [31:0]      reg_rdata_o,
  output logic [AW-1:0]    base_o,
  output logic [PTR_W-1:0] icnt_o,
  output logic             dma_en_o,
  output logic             irq_en_o,
  output logic             stat_resp_o,
  output logic             stat_ovr_o,
  output logic             wp_clr_o,
  output logic             irq_o
);

  localparam logic [7:0] SIZE_CODE = size_code(PTR_W);

  rsp_sel_e sel;
  logic wr_base, wr_icnt, wr_ctrl, wr_stat, wr_wptr;

  logic [AW-1:0]    base_q;
  logic [PTR_W-1:0] icnt_q;
  logic             dma_en_q, irq_en_q;
  logic             stat_resp_q, stat_ovr_q;

  assign sel     = rsp_sel_e'(reg_addr_i);
  assign wr_base = reg_we_i && (sel == SEL_BASE);
  assign wr_wptr = reg_we_i && (sel == SEL_WPTR);
  assign wr_icnt = reg_we_i && (sel == SEL_ICNT);
  assign wr_ctrl = reg_we_i && (sel == SEL_CTRL);
  assign wr_stat = reg_we_i && (sel == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      icnt_q   <= '0;
      dma_en_q <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_base) base_q <= reg_wdata_i[AW-1:0];
      if (wr_icnt) icnt_q <= reg_wdata_i[PTR_W-1:0];
      if (wr_ctrl) begin
        dma_en_q <= reg_wdata_i[CTRL_DMA_BIT];
        irq_en_q <= reg_wdata_i[CTRL_IRQ_BIT];
      end
    end
  end

  // set beats write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_resp_q <= 1'b0;
      stat_ovr_q  <= 1'b0;
    end else begin
      stat_resp_q <= resp_ev_i | (stat_resp_q & ~(wr_stat & reg_wdata_i[STAT_RESP_BIT]));
      stat_ovr_q  <= ovr_ev_i  | (stat_ovr_q  & ~(wr_stat & reg_wdata_i[STAT_OVR_BIT]));
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_BASE: reg_rdata_o = 32'(base_q);
      SEL_WPTR: reg_rdata_o = 32'(wp_i);
      SEL_ICNT: reg_rdata_o = 32'(icnt_q);
      SEL_CTRL: begin
        reg_rdata_o[CTRL_DMA_BIT] = dma_en_q;
        reg_rdata_o[CTRL_IRQ_BIT] = irq_en_q;
      end
      SEL_STAT: begin
        reg_rdata_o[STAT_RESP_BIT] = stat_resp_q;
        reg_rdata_o[STAT_OVR_BIT]  = stat_ovr_q;
      end
      SEL_SIZE: reg_rdata_o = 32'(SIZE_CODE);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign wp_clr_o    = wr_wptr & reg_wdata_i[WPTR_CLR_BIT];
  assign base_o      = base_q;
  assign icnt_o      = icnt_q;
  assign dma_en_o    = dma_en_q;
  assign irq_en_o    = irq_en_q;
  assign stat_resp_o = stat_resp_q;
  assign stat_ovr_o  = stat_ovr_q;
  assign irq_o       = (stat_resp_q & irq_en_q) | stat_ovr_q;

endmodule

// File: rtl/rsp_ring_ptr.sv
module rsp_ring_ptr
  import rsp_ring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             req_i,
  input  logic [PTR_W-1:0] sw_rp_i,
  input  logic [AW-1:0]    base_i,
  input  rsp_entry_t       entry_i,
  output logic [PTR_W-1:0] wp_o,
  output logic             store_o,
  output logic             full_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [63:0]      mem_wdata_o
);

  localparam int ENTRY_BYTES = $bits(rsp_entry_t) / 8;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic [PTR_W-1:0] wp_q, wp_nxt;
  logic             hit_rp;
  logic             mem_we_q;
  logic [AW-1:0]    mem_addr_q;
  rsp_entry_t       mem_data_q;

  assign wp_nxt  = wp_q + 1'b1;
  assign hit_rp  = (wp_nxt == sw_rp_i);
  assign store_o = req_i & ~clr_i & ~hit_rp;
  assign full_o  = req_i & ~clr_i &  hit_rp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0;
    end else if (store_o) begin
      wp_q <= wp_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_q   <= 1'b0;
      mem_addr_q <= '0;
      mem_data_q <= '0;
    end else begin
      mem_we_q <= store_o;
      if (store_o) begin
        mem_addr_q <= base_i + (AW'(wp_nxt) << ENTRY_SHIFT);
        mem_data_q <= entry_i;
      end
    end
  end

  assign wp_o        = wp_q;
  assign mem_we_o    = mem_we_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_data_q;

endmodule

// File: rtl/rsp_ring_thresh.sv
module rsp_ring_thresh #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PTR_W-1:0] limit_i,
  output logic             hit_o
);

  localparam int CW = PTR_W + 1;

  logic [CW-1:0] cnt_q, cnt_inc, limit_ext;

  // zero encodes the full ring size
  assign limit_ext = (limit_i == '0) ? {1'b1, {PTR_W{1'b0}}} : {1'b0, limit_i};
  assign cnt_inc   = cnt_q + 1'b1;
  // >= so a lowered limit fires on the next response
  assign hit_o     = tick_i & (cnt_inc >= limit_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= hit_o ? '0 : cnt_inc;
    end
  end

endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
  import rsp_ring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rsp_valid_i,
  input  logic [31:0]      rsp_data_i,
  input  logic [31:0]      rsp_ext_i,
  input  logic [PTR_W-1:0] sw_rp_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  output logic             irq_o
);

  logic [AW-1:0]    base;
  logic [PTR_W-1:0] icnt;
  logic [PTR_W-1:0] wp;
  logic             dma_en, irq_en;
  logic             stat_resp, stat_ovr;
  logic             wp_clr, store, full, thr_hit;
  rsp_entry_t       entry;

  assign entry.data = rsp_data_i;
  assign entry.ext  = rsp_ext_i;

  rsp_ring_regs #(.AW(AW), .PTR_W(PTR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .wp_i        (wp),
    .resp_ev_i   (thr_hit),
    .ovr_ev_i    (full),
    .reg_rdata_o (reg_rdata_o),
    .base_o      (base),
    .icnt_o      (icnt),
    .dma_en_o    (dma_en),
    .irq_en_o    (irq_en),
    .stat_resp_o (stat_resp),
    .stat_ovr_o  (stat_ovr),
    .wp_clr_o    (wp_clr),
    .irq_o       (irq_o)
  );

  rsp_ring_ptr #(.AW(AW), .PTR_W(PTR_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (wp_clr),
    .req_i       (rsp_valid_i & dma_en),
    .sw_rp_i     (sw_rp_i),
    .base_i      (base),
    .entry_i     (entry),
    .wp_o        (wp),
    .store_o     (store),
    .full_o      (full),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  rsp_ring_thresh #(.PTR_W(PTR_W)) u_thresh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wp_clr),
    .tick_i  (store),
    .limit_i (icnt),
    .hit_o   (thr_hit)
  );

endmodule

// File: rtl/rsp_ring_chk.sv
module rsp_ring_chk #(
  parameter int AW    = 32,
  parameter int PTR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rsp_valid_i,
  input logic [PTR_W-1:0] sw_rp_i,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             irq_o,
  input logic [PTR_W-1:0] wp,
  input logic [AW-1:0]    base,
  input logic             dma_en,
  input logic             stat_resp,
  input logic             stat_ovr
);

  logic             clr_req, full_req;
  logic [PTR_W-1:0] wp_inc;

  assign wp_inc   = wp + 1'b1;
  assign clr_req  = reg_we_i && (reg_addr_i == 3'd1) && reg_wdata_i[15];
  assign full_req = rsp_valid_i && dma_en && !clr_req && (wp_inc == sw_rp_i);

  p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && dma_en && !clr_req && (wp_inc != sw_rp_i)) |=>
      (mem_we_o && (wp == $past(wp_inc)) &&
       (mem_addr_o == $past(base) + (AW'($past(wp_inc)) << 3))));

  p_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_en && !clr_req) |=> (!mem_we_o && $stable(wp)));

  p_wpclr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> (wp == '0 && !mem_we_o));

  p_overrun_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_req |=> (stat_ovr && !mem_we_o && $stable(wp)));

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd4 && reg_wdata_i[2] && !full_req) |=> !stat_ovr);

  p_irq_ovr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_ovr |-> irq_o);

  p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_ovr && !stat_resp) |-> !irq_o);

endmodule

bind rsp_ring_writer rsp_ring_chk #(.AW(AW), .PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rsp_valid_i (rsp_valid_i),
  .sw_rp_i     (sw_rp_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .irq_o       (irq_o),
  .wp          (wp),
  .base        (base),
  .dma_en      (dma_en),
  .stat_resp   (stat_resp),
  .stat_ovr    (stat_ovr)
);

// File: tb/rsp_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rsp_ring_writer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0, rsp_ext = '0;
  logic [7:0]  sw_rp = 8'h80;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference model
  int   m_wp = 0, m_cnt = 0, m_lim = 0;
  bit   m_resp = 0, m_ovr = 0, m_dma = 0, m_irqen = 0;
  logic [31:0] m_base = '0;

  always #5 clk = ~clk;

  rsp_ring_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .rsp_ext_i(rsp_ext),
    .sw_rp_i(sw_rp),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .irq_o(irq)
  );

  function automatic int lim_eff(input int l);
    return (l == 0) ? 256 : l;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input int wp);
    return b + 32'(wp * 8);
  endfunction

  function automatic bit exp_irq();
    return (m_resp && m_irqen) || m_ovr;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: m_base = d;
      3'd1: if (d[15]) begin m_wp = 0; m_cnt = 0; end
      3'd2: m_lim = int'(d[7:0]);
      3'd3: begin m_dma = d[1]; m_irqen = d[0]; end
      3'd4: begin if (d[0]) m_resp = 0; if (d[2]) m_ovr = 0; end
      default: ;
    endcase
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_wp(input string req);
    logic [31:0] v;
    reg_rd(3'd1, v);
    chk(v == 32'(m_wp), req, 64'(v), 64'(m_wp));
  endtask

  task automatic send(input logic [31:0] d, input logic [31:0] e, input logic [7:0] rp, input string req);
    bit exp_we;
    int nwp;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d; rsp_ext = e; sw_rp = rp;
    nwp = (m_wp + 1) % 256;
    exp_we = 1'b0;
    if (m_dma) begin
      if (8'(nwp) == rp) m_ovr = 1;
      else begin
        exp_we = 1'b1;
        m_wp = nwp;
        m_cnt++;
        if (m_cnt >= lim_eff(m_lim)) begin m_resp = 1; m_cnt = 0; end
      end
    end
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(mem_we == exp_we, req, 64'(mem_we), 64'(exp_we));
    if (exp_we) begin
      chk(mem_addr == exp_addr(m_base, m_wp), req, 64'(mem_addr), 64'(exp_addr(m_base, m_wp)));
      chk(mem_wdata == {e, d}, req, mem_wdata, {e, d});
    end
    chk(irq == exp_irq(), "R9", 64'(irq), 64'(exp_irq()));
  endtask

  task automatic chk_stat(input string req);
    logic [31:0] v;
    logic [31:0] e;
    reg_rd(3'd4, v);
    e = {29'd0, m_ovr, 1'b0, m_resp};
    chk(v == e, req, 64'(v), 64'(e));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(mem_we == 1'b0, "R1", 64'(mem_we), 0);
    chk(irq == 1'b0, "R1", 64'(irq), 0);
    chk_wp("R1");
    chk_stat("R1");
    reg_rd(3'd5, v);
    chk(v == 32'h2, "R1", 64'(v), 64'h2);

    // R10 readback
    reg_wr(3'd0, 32'h1000_0000);
    reg_wr(3'd2, 32'h1);
    reg_rd(3'd0, v); chk(v == 32'h1000_0000, "R10", 64'(v), 64'h1000_0000);
    reg_rd(3'd2, v); chk(v == 32'h1, "R10", 64'(v), 64'h1);
    reg_wr(3'd3, 32'h2);
    reg_rd(3'd3, v); chk(v == 32'h2, "R10", 64'(v), 64'h2);
    reg_wr(3'd3, 32'h0);

    // R3 DMA off: ignored
    for (int i = 0; i < 3; i++) send(32'hdead_0000 + 32'(i), 32'h0, 8'h80, "R3");
    chk_wp("R3");
    chk_stat("R3");

    // R2/R5/R9 N=1
    reg_wr(3'd3, 32'h3);
    send(32'hcafe_0001, 32'h0000_0002, 8'h80, "R2");
    chk_wp("R2");
    chk_stat("R5");
    // R8 write 0 leaves, write 1 clears
    reg_wr(3'd4, 32'h0);
    chk_stat("R8");
    reg_wr(3'd4, 32'h1);
    chk_stat("R8");
    chk(irq == 1'b0, "R9", 64'(irq), 0);

    // R5 N=4
    reg_wr(3'd2, 32'h4);
    for (int i = 0; i < 3; i++) send(32'h0bad_0000 + 32'(i), 32'h1, 8'h80, "R5");
    chk_stat("R5");
    send(32'h0bad_0003, 32'h1, 8'h80, "R5");
    chk_stat("R5");
    reg_wr(3'd4, 32'h1);

    // R6 unsolicited marker stored and counted
    reg_wr(3'd2, 32'h2);
    send(32'h1234_5678, 32'h0000_0010, 8'h80, "R6");
    send(32'h8765_4321, 32'hffff_ffff, 8'h80, "R6");
    chk_stat("R6");
    reg_wr(3'd4, 32'h1);

    // R4 pointer clear
    reg_wr(3'd1, 32'h0000_0005);
    chk_wp("R4");
    reg_wr(3'd1, 32'h0000_8000);
    chk_wp("R4");
    send(32'h0000_00aa, 32'h0, 8'h80, "R4");
    chk(mem_addr == 32'h1000_0008, "R4", 64'(mem_addr), 64'h1000_0008);
    // clear wins over simultaneous response
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = 32'h5555_5555; rsp_ext = 32'h0;
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h8000;
    @(negedge clk);
    rsp_valid = 1'b0; reg_we = 1'b0;
    m_wp = 0; m_cnt = 0;
    chk(mem_we == 1'b0, "R4", 64'(mem_we), 0);
    chk_wp("R4");

    // R7 overrun, irq enable off
    reg_wr(3'd3, 32'h2);
    send(32'h0f0f_0f0f, 32'h0, 8'(m_wp + 1), "R7");
    chk_wp("R7");
    chk_stat("R7");
    chk(irq == 1'b1, "R9", 64'(irq), 1);
    reg_wr(3'd4, 32'h4);
    chk_stat("R8");
    reg_wr(3'd3, 32'h3);

    // R8 set wins over simultaneous clear
    reg_wr(3'd2, 32'h1);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = 32'h7777_0000; rsp_ext = 32'h0; sw_rp = 8'(m_wp + 100);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
    @(negedge clk);
    rsp_valid = 1'b0; reg_we = 1'b0;
    m_wp = (m_wp + 1) % 256; m_resp = 1; m_cnt = 0;
    chk(mem_we == 1'b1, "R8", 64'(mem_we), 1);
    chk_stat("R8");
    reg_wr(3'd4, 32'h5);

    // random traffic, wraps the ring
    for (int i = 0; i < 900; i++) begin
      int op;
      op = int'($urandom % 20);
      if (op == 0) reg_wr(3'd4, $urandom & 32'h5);
      else if (op == 1) reg_wr(3'd2, ($urandom % 6 == 0) ? 32'h0 : 32'(1 + $urandom % 7));
      else if (op == 2 && ($urandom % 8 == 0)) reg_wr(3'd1, 32'h8000);
      else if (op == 3) reg_wr(3'd3, 32'($urandom % 4) | 32'h2);
      else begin
        logic [7:0] rp;
        rp = ($urandom % 12 == 0) ? 8'(m_wp + 1) : 8'(m_wp + 2 + int'($urandom % 200));
        send($urandom, $urandom, rp, "R2");
      end
      if (i % 32 == 0) begin
        chk_wp("R2");
        chk_stat("R5");
      end
    end
    chk_wp("R2");
    chk_stat("R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule